// File: doc/BRIEF.md
# Asynchronous SRAM Interface Controller

This block lets clocked on-chip logic read and write an external asynchronous static RAM of 128K bytes. The memory has a 17-bit address, a shared 8-bit bidirectional data bus and four strobes: a low-active select, a high-active select, a low-active output enable and a low-active write enable. The bidirectional bus is split into a data-out vector, a driver enable and a data-in vector, so the pad tristate sits outside this block.

The user side is a request port. The user presents an address, write data and a read/write flag together with a request pulse while `busy` is low. `busy` then stays high until the access has ended and the memory is deselected again. A read returns its byte on `rdata` with a one-cycle `rvalid` strobe. Every datasheet limit is a nanosecond parameter. At elaboration each limit becomes a whole number of clock cycles, rounded up from the clock period. All memory-side outputs come straight from flip-flops.

Top module: `sram_async_ctrl`

## Requirements
- R1: While reset is held, the memory is deselected (low-active select high, high-active select low), write and output enables are high, the data drivers are off, and `busy` and `rvalid` are low.
- R2: A request is taken only when `busy` is low. `busy` is high in the cycle after acceptance and stays high until the access completes. Requests raised while `busy` is high are ignored and write nothing.
- R3: For a write, address and both selects are applied one cycle before write enable falls, and output enable stays high for the whole write.
- R4: The data drivers turn on only after write enable has been low for the bus-release time: 1 cycle at the default 10 ns period. They are still on in the cycle where write enable rises, off one cycle later, and never on while output enable is low.
- R5: Write enable stays low for the largest of the pulse width, the release time plus data setup, and the address and cycle-time budgets. At the defaults this is 2 cycles. The written byte is the one on the data-out vector when the write overlap ends.
- R6: For a read, output enable is low for the largest of the read-cycle, address-access and output-enable-access times: 2 cycles at the defaults. The byte on `mem_din` is captured at the end of that window. `rvalid` pulses for exactly one cycle with that byte on `rdata`.
- R7: Every access ends with at least one deselected cycle before the next one starts. At the defaults a write keeps the memory selected for 4 cycles and a read for 2.
- R8: Write enable is low only while both selects are active.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req | input | 1 | Access request, taken when busy is low |
| wr | input | 1 | 1 = write, 0 = read |
| addr | input | 17 | Word address |
| wdata | input | 8 | Write byte |
| busy | output | 1 | Access in progress |
| rdata | output | 8 | Read byte |
| rvalid | output | 1 | One-cycle strobe for rdata |
| mem_addr | output | 17 | Memory address |
| mem_dout | output | 8 | Byte driven toward the memory |
| mem_doe | output | 1 | Data driver enable |
| mem_din | input | 8 | Byte from the memory bus |
| mem_ce1_n | output | 1 | Low-active chip select |
| mem_ce2 | output | 1 | High-active chip select |
| mem_oe_n | output | 1 | Low-active output enable |
| mem_we_n | output | 1 | Low-active write enable |

## Verification
The bench drives several traffic patterns. Writes to the lowest and highest addresses check that every address bit reaches the memory. Walking-one addresses carrying walking-one data, read back in reverse order, expose swapped or stuck address and data lines. Back-to-back write and read of one location, followed by an overwrite of it, show that the stored byte is taken at the end of the overlap and that the turnaround gap is present. A request held high during a write shows that busy gates acceptance. Throughout, a monitor measures the strobe windows in cycles and flags any overlap between the controller's drivers and the memory's outputs.

// File: rtl/sram_async_ctrl.sv
module sram_async_ctrl #(
  parameter int CLK_NS  = 10,
  parameter int ADDR_W  = 17,
  parameter int DATA_W  = 8,
  parameter int T_WC    = 12,
  parameter int T_PWE   = 10,
  parameter int T_AW    = 10,
  parameter int T_SD    = 7,
  parameter int T_HZWE  = 7,
  parameter int T_RC    = 12,
  parameter int T_AA    = 12,
  parameter int T_DOE   = 6
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req,
  input  logic              wr,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] wdata,
  output logic              busy,
  output logic [DATA_W-1:0] rdata,
  output logic              rvalid,
  output logic [ADDR_W-1:0] mem_addr,
  output logic [DATA_W-1:0] mem_dout,
  output logic              mem_doe,
  input  logic [DATA_W-1:0] mem_din,
  output logic              mem_ce1_n,
  output logic              mem_ce2,
  output logic              mem_oe_n,
  output logic              mem_we_n
);

  function automatic int cyc(input int ns);
    int c;
    c = (ns + CLK_NS - 1) / CLK_NS;
    return (c < 1) ? 1 : c;
  endfunction

  function automatic int max2(input int a, input int b);
    return (a > b) ? a : b;
  endfunction

  localparam int N_HZ   = cyc(T_HZWE);
  localparam int N_WLOW = max2(max2(cyc(T_PWE), N_HZ + cyc(T_SD)),
                               max2(cyc(T_AW) - 1, cyc(T_WC) - 2));
  localparam int N_RD   = max2(max2(cyc(T_RC), cyc(T_AA)), cyc(T_DOE));
  localparam int N_MAX  = max2(N_WLOW, N_RD);
  localparam int CW     = $clog2(N_MAX + 1) + 1;

  typedef enum logic [2:0] {ST_IDLE, ST_WSET, ST_WLOW, ST_WHOLD, ST_READ, ST_GAP} st_t;

  st_t           st;
  logic [CW-1:0] cnt;
  wire  [CW-1:0] cnt_nx = cnt + 1'b1;
  wire           selected = !mem_ce1_n && mem_ce2;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st        <= ST_IDLE;
      cnt       <= '0;
      busy      <= 1'b0;
      rvalid    <= 1'b0;
      rdata     <= '0;
      mem_addr  <= '0;
      mem_dout  <= '0;
      mem_doe   <= 1'b0;
      mem_ce1_n <= 1'b1;
      mem_ce2   <= 1'b0;
      mem_oe_n  <= 1'b1;
      mem_we_n  <= 1'b1;
    end else begin
      rvalid <= 1'b0;
      case (st)
        ST_IDLE: if (req) begin
          busy      <= 1'b1;
          mem_addr  <= addr;
          mem_ce1_n <= 1'b0;
          mem_ce2   <= 1'b1;
          cnt       <= '0;
          if (wr) begin
            mem_dout <= wdata;
            st       <= ST_WSET;
          end else begin
            mem_oe_n <= 1'b0;
            st       <= ST_READ;
          end
        end
        ST_WSET: begin
          mem_we_n <= 1'b0;
          cnt      <= '0;
          st       <= ST_WLOW;
        end
        ST_WLOW: begin
          cnt <= cnt_nx;
          if (cnt_nx == CW'(N_HZ)) mem_doe <= 1'b1;
          if (cnt_nx == CW'(N_WLOW)) begin
            mem_we_n <= 1'b1;
            st       <= ST_WHOLD;
          end
        end
        ST_WHOLD: begin
          mem_doe   <= 1'b0;
          mem_ce1_n <= 1'b1;
          mem_ce2   <= 1'b0;
          st        <= ST_GAP;
        end
        ST_READ: begin
          cnt <= cnt_nx;
          if (cnt_nx == CW'(N_RD)) begin
            rdata     <= mem_din;
            rvalid    <= 1'b1;
            mem_oe_n  <= 1'b1;
            mem_ce1_n <= 1'b1;
            mem_ce2   <= 1'b0;
            st        <= ST_GAP;
          end
        end
        ST_GAP: begin
          busy <= 1'b0;
          st   <= ST_IDLE;
        end
        default: st <= ST_IDLE;
      endcase
    end
  end

  assert_idle_deselected_R7: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> (mem_ce1_n && !mem_ce2 && mem_we_n && mem_oe_n && !mem_doe));

  assert_we_only_selected_R8: assert property (@(posedge clk) disable iff (!rst_n)
    !mem_we_n |-> (selected && mem_oe_n));

  assert_no_contention_R4: assert property (@(posedge clk) disable iff (!rst_n)
    mem_doe |-> mem_oe_n);

  assert_drive_after_we_R4: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(mem_doe) |-> !mem_we_n);

  assert_write_end_held_R5: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(mem_we_n) |-> (mem_doe && selected && $stable(mem_addr) && $stable(mem_dout)));

  assert_rvalid_pulse_R6: assert property (@(posedge clk) disable iff (!rst_n)
    rvalid |=> !rvalid);

  assert_busy_from_req_R2: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy) |-> $past(req));

endmodule

// File: tb/sram_async_ctrl_tb.sv
module sram_async_ctrl_tb_top;
  localparam int EXP_HZ   = 1;
  localparam int EXP_WLOW = 2;
  localparam int EXP_RD   = 2;
  localparam int EXP_WRUN = EXP_WLOW + 2;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req = 1'b0, wr = 1'b0;
  logic [16:0] addr = '0;
  logic [7:0]  wdata = '0;
  logic        busy, rvalid;
  logic [7:0]  rdata;
  logic [16:0] mem_addr;
  logic [7:0]  mem_dout, mem_din;
  logic        mem_doe, mem_ce1_n, mem_ce2, mem_oe_n, mem_we_n;
  logic [7:0]  din_q = 8'hzz;

  always #5 clk = ~clk;
  assign mem_din = din_q;

  sram_async_ctrl dut_i (
    .clk(clk), .rst_n(rst_n), .req(req), .wr(wr), .addr(addr), .wdata(wdata),
    .busy(busy), .rdata(rdata), .rvalid(rvalid),
    .mem_addr(mem_addr), .mem_dout(mem_dout), .mem_doe(mem_doe), .mem_din(mem_din),
    .mem_ce1_n(mem_ce1_n), .mem_ce2(mem_ce2), .mem_oe_n(mem_oe_n), .mem_we_n(mem_we_n)
  );

  int checks = 0, errors = 0;
  logic [7:0] sram [int];
  logic [7:0] refm [int];
  logic [7:0] expq [$];

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic finish_sim();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  endtask

  // memory model: stores at the end of the write overlap, drives while reading
  bit prev_wov = 1'b0;
  always @(posedge clk) begin
    bit wov;
    #1;
    wov = !mem_ce1_n && mem_ce2 && !mem_we_n;
    if (prev_wov && !wov) begin
      chk(mem_doe, "R5 data driven at write end", int'(mem_doe), 1);
      sram[int'(mem_addr)] = mem_dout;
    end
    prev_wov = wov;
    if (!mem_ce1_n && mem_ce2 && !mem_oe_n && mem_we_n)
      din_q = sram.exists(int'(mem_addr)) ? sram[int'(mem_addr)] : 8'h00;
    else
      din_q = 8'hzz;
  end

  // monitor: strobe windows and scoreboard
  int  we_low = 0, sel_run = 0, oe_run = 0;
  bit  prev_we_n = 1'b1, prev_doe = 1'b0, prev_rvalid = 1'b0, doe_off_pending = 1'b0;
  always @(negedge clk) if (rst_n) begin
    bit sel;
    sel = !mem_ce1_n && mem_ce2;
    if (!mem_we_n) begin
      we_low++;
      chk(sel, "R8 selected during write enable", int'(sel), 1);
      chk(mem_oe_n, "R3 output enable high in write", int'(mem_oe_n), 1);
    end
    if (mem_doe && !prev_doe)
      chk(!mem_we_n && we_low == EXP_HZ + 1, "R4 driver turn-on delay", we_low, EXP_HZ + 1);
    if (mem_doe)
      chk(mem_oe_n, "R4 no driver with output enable low", int'(mem_oe_n), 1);
    if (mem_we_n && !prev_we_n) begin
      chk(we_low == EXP_WLOW, "R5 write enable low cycles", we_low, EXP_WLOW);
      chk(mem_doe, "R4 drivers held at write enable rise", int'(mem_doe), 1);
      doe_off_pending = 1'b1;
      we_low = 0;
    end else if (doe_off_pending) begin
      chk(!mem_doe, "R4 drivers off one cycle later", int'(mem_doe), 0);
      doe_off_pending = 1'b0;
    end
    if (sel) sel_run++;
    else if (sel_run != 0) begin
      chk(sel_run == EXP_WRUN || sel_run == EXP_RD, "R7 select run then gap", sel_run, EXP_WRUN);
      sel_run = 0;
    end
    if (!mem_oe_n) oe_run++;
    else if (oe_run != 0) begin
      chk(oe_run == EXP_RD, "R6 output enable low cycles", oe_run, EXP_RD);
      oe_run = 0;
    end
    if (rvalid) begin
      chk(!prev_rvalid, "R6 rvalid single cycle", int'(prev_rvalid), 0);
      if (expq.size() == 0) chk(1'b0, "R6 unexpected rvalid", int'(rdata), 0);
      else begin
        logic [7:0] e;
        e = expq.pop_front();
        chk(rdata == e, "R6 read data", int'(rdata), int'(e));
      end
    end
    prev_we_n   = mem_we_n;
    prev_doe    = mem_doe;
    prev_rvalid = rvalid;
  end

  task automatic access(input bit w, input logic [16:0] a, input logic [7:0] d);
    @(negedge clk);
    while (busy) @(negedge clk);
    req = 1'b1; wr = w; addr = a; wdata = d;
    @(posedge clk);
    #1 req = 1'b0;
    chk(busy, "R2 busy after accept", int'(busy), 1);
    if (w) refm[int'(a)] = d;
    else expq.push_back(refm.exists(int'(a)) ? refm[int'(a)] : 8'h00);
  endtask

  initial begin
    #(200000 * 10);
    checks++;
    errors++;
    $display("FAIL watchdog expired actual=0 expected=1");
    finish_sim();
  end

  initial begin
    repeat (3) @(negedge clk);
    chk(mem_ce1_n && !mem_ce2, "R1 deselected in reset", int'({mem_ce1_n, mem_ce2}), 2);
    chk(mem_we_n && mem_oe_n, "R1 strobes high in reset", int'({mem_we_n, mem_oe_n}), 3);
    chk(!mem_doe && !busy && !rvalid, "R1 driver busy rvalid low", int'({mem_doe, busy, rvalid}), 0);
    @(posedge clk);
    #1 rst_n = 1'b1;

    access(1'b1, 17'h00000, 8'hA5);
    access(1'b1, 17'h1FFFF, 8'h5A);
    access(1'b0, 17'h00000, 8'h00);
    access(1'b0, 17'h1FFFF, 8'h00);

    for (int i = 0; i < 8; i++) access(1'b1, 17'(1 << (2 * i)), 8'(1 << i));
    for (int i = 7; i >= 0; i--) access(1'b0, 17'(1 << (2 * i)), 8'h00);

    access(1'b1, 17'h12345, 8'hC3);
    access(1'b0, 17'h12345, 8'h00);
    access(1'b1, 17'h12345, 8'h3C);
    access(1'b0, 17'h12345, 8'h00);

    // R2: request while busy is ignored
    access(1'b1, 17'h00777, 8'h11);
    @(negedge clk);
    req = 1'b1; wr = 1'b1; addr = 17'h00888; wdata = 8'hEE;
    repeat (2) begin
      @(negedge clk);
      chk(busy, "R2 busy held while request pending", int'(busy), 1);
    end
    req = 1'b0;
    access(1'b0, 17'h00888, 8'h00);
    access(1'b0, 17'h00777, 8'h00);

    repeat (10) @(negedge clk);
    chk(!busy, "R2 busy released at end", int'(busy), 0);
    chk(expq.size() == 0, "R6 every read returned", expq.size(), 0);
    finish_sim();
  end
endmodule